// File: doc/BRIEF.md
# Compact Byte Processor Core

A small multi-cycle processor that fetches 16-bit instruction words from a synchronous program memory port and runs them one at a time. It has thirty-two 8-bit general registers, a private space of 64 byte-wide I/O registers, and a byte-wide data memory port with a 16-bit address. A fetch, decode and execute state machine moves the program counter forward. Register operations take three cycles, direct stores take five and direct loads take six.

Every write to the I/O space appears on a registered event port. A system can react to output writes there, and a bench can observe them. Data memory stores appear on the data port as one-cycle write strobes. Illegal words execute as no-ops.

Top module: `byte_core`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter to 0. In the cycle after reset, `imem_addr` is 0, and `dmem_we` and `io_we` are low.
- R2: Bits [15:12] of a word hold the opcode, bits [11:7] hold register d and bits [6:2] hold register r. Opcode 1 copies r into d. Opcode 2 writes d OR r into d, opcode 3 writes d AND r, opcode 4 writes d+r mod 256, and opcode 5 writes d−r mod 256 with no carry-in. Register r keeps its value in every case.
- R3: Opcode 6 multiplies d and r as unsigned values. The 16-bit product goes to r1:r0, with the low byte in r0. The operands stay unchanged.
- R4: Opcode 7 acts on register d, selected by bits [1:0]. Value 0 increments d mod 256. Value 1 shifts d left and puts 0 into bit 0. Value 2 replaces d with its two's complement, and 0x80 stays 0x80.
- R5: Opcode 8 writes the constant in bits [7:0] to register 16 + bits[11:8]. Registers 0 to 15 cannot be written by this opcode.
- R6: Opcode 9 is followed by a word holding a full 16-bit address. That address is driven on `dmem_addr`, and the byte returned on `dmem_rdata` is written to register d (bits [11:7]).
- R7: Opcode 0xA is followed by a 16-bit address word. The core pulses `dmem_we` for exactly one cycle with that address and the value of the register in bits [11:7].
- R8: The program counter moves by 2 after a two-word instruction and by 1 after any other non-jump word. The next fetch uses the new value.
- R9: Opcode 0xB writes the register in bits [11:7] to I/O address bits [5:0], which range over 0–63. The write appears as a one-cycle `io_we` pulse with address and data.
- R10: Opcode 0xC sets bit [2:0] of the I/O register at address [11:7], so only addresses 0–31 are reachable. The other bits keep their stored values. The resulting byte is reported on the `io_we` ports.
- R11: Opcode 0xD sets the program counter to PC + 1 + the sign-extended offset in bits [11:0]. An offset of −1 holds the program counter in place.
- R12: Opcodes 0, 0xE and 0xF, and opcode 7 with bits [1:0] = 3, execute as no-ops. They change no register, memory or I/O value, and the program counter advances by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Program word address (the program counter) |
| imem_data | input | 16 | Program word, valid one cycle after its address |
| dmem_addr | output | DA_W | Data memory byte address |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | 8 | Data memory write byte |
| dmem_rdata | input | 8 | Data memory read byte, valid one cycle after its address |
| io_we | output | 1 | I/O register write event |
| io_addr | output | IO_AW | I/O register address of the event |
| io_wdata | output | 8 | Byte written to the I/O register |

## Verification
The assertions rely on both memories answering one cycle after they receive an address. They also rely on the program memory never feeding the core an undefined word. The bench models both memories as registered reads. Data reads return an arithmetic function of the address. Every program is built from fully written words and ends in a jump-to-self, so fetching never leaves the written region.

// File: rtl/bc_pkg.sv
package bc_pkg;
  localparam int DATA_W  = 8;
  localparam int WORD_W  = 16;
  localparam int NREG    = 32;
  localparam int RIDX_W  = $clog2(NREG);
  localparam int JOFF_W  = 12;

  localparam logic [3:0] OPC_COPY = 4'h1;
  localparam logic [3:0] OPC_OR   = 4'h2;
  localparam logic [3:0] OPC_AND  = 4'h3;
  localparam logic [3:0] OPC_ADD  = 4'h4;
  localparam logic [3:0] OPC_SUB  = 4'h5;
  localparam logic [3:0] OPC_MUL  = 4'h6;
  localparam logic [3:0] OPC_UNA  = 4'h7;
  localparam logic [3:0] OPC_IMM  = 4'h8;
  localparam logic [3:0] OPC_LDD  = 4'h9;
  localparam logic [3:0] OPC_STD  = 4'hA;
  localparam logic [3:0] OPC_OUT  = 4'hB;
  localparam logic [3:0] OPC_SETB = 4'hC;
  localparam logic [3:0] OPC_JMP  = 4'hD;

  typedef enum logic [2:0] {
    ST_FETCH, ST_LATCH, ST_EXEC, ST_FETCH2, ST_LATCH2, ST_MEM, ST_LOADWB
  } state_e;

  typedef enum logic [3:0] {
    AL_COPY, AL_OR, AL_AND, AL_ADD, AL_SUB, AL_INC, AL_LSL, AL_NEG, AL_MUL
  } alu_op_e;

  typedef enum logic [2:0] {
    K_NOP, K_ALU, K_LDI, K_LDD, K_STD, K_OUT, K_SETB, K_JMP
  } kind_e;

  typedef struct packed {
    kind_e               kind;
    alu_op_e             aop;
    logic [RIDX_W-1:0]   rd;
    logic [RIDX_W-1:0]   rr;
    logic [5:0]          io_a;
    logic [2:0]          bitsel;
    logic [DATA_W-1:0]   imm;
    logic [JOFF_W-1:0]   off;
  } dec_t;

  function automatic logic is_two_word(input logic [WORD_W-1:0] w);
    return (w[15:12] == OPC_LDD) || (w[15:12] == OPC_STD);
  endfunction
endpackage

// File: rtl/bc_decode.sv
module bc_decode
  import bc_pkg::*;
(
  input  logic [WORD_W-1:0] ir,
  output dec_t              dec
);
  always_comb begin
    dec        = '0;
    dec.kind   = K_NOP;
    dec.aop    = AL_COPY;
    dec.rd     = ir[11:7];
    dec.rr     = ir[6:2];
    dec.imm    = ir[7:0];
    dec.off    = ir[11:0];
    dec.bitsel = ir[2:0];
    dec.io_a   = ir[5:0];
    case (ir[15:12])
      OPC_COPY: begin dec.kind = K_ALU; dec.aop = AL_COPY; end
      OPC_OR:   begin dec.kind = K_ALU; dec.aop = AL_OR;   end
      OPC_AND:  begin dec.kind = K_ALU; dec.aop = AL_AND;  end
      OPC_ADD:  begin dec.kind = K_ALU; dec.aop = AL_ADD;  end
      OPC_SUB:  begin dec.kind = K_ALU; dec.aop = AL_SUB;  end
      OPC_MUL:  begin dec.kind = K_ALU; dec.aop = AL_MUL;  end
      OPC_UNA: begin
        case (ir[1:0])
          2'd0:    begin dec.kind = K_ALU; dec.aop = AL_INC; end
          2'd1:    begin dec.kind = K_ALU; dec.aop = AL_LSL; end
          2'd2:    begin dec.kind = K_ALU; dec.aop = AL_NEG; end
          default: dec.kind = K_NOP;
        endcase
      end
      OPC_IMM: begin
        dec.kind = K_LDI;
        dec.rd   = {1'b1, ir[11:8]};
      end
      OPC_LDD: dec.kind = K_LDD;
      OPC_STD: begin dec.kind = K_STD; dec.rr = ir[11:7]; end
      OPC_OUT: begin dec.kind = K_OUT; dec.rr = ir[11:7]; end
      OPC_SETB: begin
        dec.kind = K_SETB;
        dec.io_a = {1'b0, ir[11:7]};
      end
      OPC_JMP: dec.kind = K_JMP;
      default: dec.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/bc_alu.sv
module bc_alu
  import bc_pkg::*;
(
  input  alu_op_e             op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  output logic [DATA_W-1:0]   res,
  output logic [2*DATA_W-1:0] prod
);
  always_comb begin
    prod = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
    case (op)
      AL_COPY: res = b;
      AL_OR:   res = a | b;
      AL_AND:  res = a & b;
      AL_ADD:  res = a + b;
      AL_SUB:  res = a - b;
      AL_INC:  res = a + DATA_W'(1);
      AL_LSL:  res = {a[DATA_W-2:0], 1'b0};
      AL_NEG:  res = DATA_W'(0) - a;
      AL_MUL:  res = prod[DATA_W-1:0];
      default: res = a;
    endcase
  end
endmodule

// File: rtl/bc_regs.sv
module bc_regs
  import bc_pkg::*;
#(
  parameter int N  = NREG,
  parameter int AW = $clog2(N)
) (
  input  logic              clk,
  input  logic [AW-1:0]     ra_a,
  input  logic [AW-1:0]     ra_b,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd,
  input  logic              we_hi,
  input  logic [DATA_W-1:0] wd_hi
);
  logic [DATA_W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we)    mem[wa]      <= wd;
    if (we_hi) mem[AW'(1)]  <= wd_hi;
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];
endmodule

// File: rtl/bc_io.sv
module bc_io
  import bc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [AW-1:0]     ra,
  output logic [DATA_W-1:0] rd
);
  logic [DATA_W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd = regs[ra];
endmodule

// File: rtl/byte_core.sv
module byte_core
  import bc_pkg::*;
#(
  parameter int PC_W  = 10,
  parameter int DA_W  = 16,
  parameter int IO_N  = 64,
  parameter int IO_AW = $clog2(IO_N)
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [WORD_W-1:0]  imem_data,
  output logic [DA_W-1:0]    dmem_addr,
  output logic               dmem_we,
  output logic [DATA_W-1:0]  dmem_wdata,
  input  logic [DATA_W-1:0]  dmem_rdata,
  output logic               io_we,
  output logic [IO_AW-1:0]   io_addr,
  output logic [DATA_W-1:0]  io_wdata
);
  localparam int OFF_EXT = (PC_W > JOFF_W) ? PC_W : JOFF_W;

  state_e              state_q;
  logic [PC_W-1:0]     pc_q;
  logic [WORD_W-1:0]   ir_q;
  dec_t                dec;

  logic [DATA_W-1:0]   rf_a, rf_b, alu_res, io_rd;
  logic [2*DATA_W-1:0] prod;
  logic                rf_we, rf_we_hi, io_we_c;
  logic [RIDX_W-1:0]   rf_wa;
  logic [DATA_W-1:0]   rf_wd, io_wd_c;
  logic [OFF_EXT-1:0]  off_ext;
  logic [PC_W-1:0]     pc_inc, pc_jump;

  logic [DA_W-1:0]     dmem_addr_q;
  logic                dmem_we_q;
  logic [DATA_W-1:0]   dmem_wdata_q;
  logic                io_we_q;
  logic [IO_AW-1:0]    io_addr_q;
  logic [DATA_W-1:0]   io_wdata_q;

  bc_decode u_dec (.ir(ir_q), .dec(dec));

  bc_alu u_alu (.op(dec.aop), .a(rf_a), .b(rf_b), .res(alu_res), .prod(prod));

  bc_regs #(.N(NREG)) u_regs (
    .clk(clk), .ra_a(dec.rd), .ra_b(dec.rr), .rd_a(rf_a), .rd_b(rf_b),
    .we(rf_we), .wa(rf_wa), .wd(rf_wd), .we_hi(rf_we_hi), .wd_hi(prod[2*DATA_W-1:DATA_W])
  );

  bc_io #(.DEPTH(IO_N), .AW(IO_AW)) u_io (
    .clk(clk), .rst(rst), .we(io_we_c), .wa(IO_AW'(dec.io_a)), .wd(io_wd_c),
    .ra(IO_AW'(dec.io_a)), .rd(io_rd)
  );

  assign off_ext = OFF_EXT'($signed(dec.off));
  assign pc_inc  = pc_q + PC_W'(1);
  assign pc_jump = pc_inc + off_ext[PC_W-1:0];

  always_comb begin
    rf_we    = 1'b0;
    rf_we_hi = 1'b0;
    rf_wa    = dec.rd;
    rf_wd    = alu_res;
    io_we_c  = 1'b0;
    io_wd_c  = rf_b;
    if (state_q == ST_EXEC) begin
      case (dec.kind)
        K_ALU: begin
          rf_we = 1'b1;
          if (dec.aop == AL_MUL) begin
            rf_wa    = '0;
            rf_wd    = prod[DATA_W-1:0];
            rf_we_hi = 1'b1;
          end
        end
        K_LDI: begin
          rf_we = 1'b1;
          rf_wd = dec.imm;
        end
        K_OUT: io_we_c = 1'b1;
        K_SETB: begin
          io_we_c = 1'b1;
          io_wd_c = io_rd | (DATA_W'(1) << dec.bitsel);
        end
        default: ;
      endcase
    end else if (state_q == ST_LOADWB) begin
      rf_we = 1'b1;
      rf_wd = dmem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_FETCH;
      pc_q         <= '0;
      ir_q         <= '0;
      dmem_addr_q  <= '0;
      dmem_we_q    <= 1'b0;
      dmem_wdata_q <= '0;
      io_we_q      <= 1'b0;
      io_addr_q    <= '0;
      io_wdata_q   <= '0;
    end else begin
      dmem_we_q <= 1'b0;
      io_we_q   <= 1'b0;
      case (state_q)
        ST_FETCH: state_q <= ST_LATCH;
        ST_LATCH: begin
          ir_q <= imem_data;
          if (is_two_word(imem_data)) begin
            pc_q    <= pc_inc;
            state_q <= ST_FETCH2;
          end else begin
            state_q <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          pc_q       <= (dec.kind == K_JMP) ? pc_jump : pc_inc;
          io_we_q    <= io_we_c;
          io_addr_q  <= IO_AW'(dec.io_a);
          io_wdata_q <= io_wd_c;
          state_q    <= ST_FETCH;
        end
        ST_FETCH2: state_q <= ST_LATCH2;
        ST_LATCH2: begin
          pc_q        <= pc_inc;
          dmem_addr_q <= DA_W'(imem_data);
          if (dec.kind == K_STD) begin
            dmem_we_q    <= 1'b1;
            dmem_wdata_q <= rf_b;
          end
          state_q <= ST_MEM;
        end
        ST_MEM:    state_q <= (dec.kind == K_LDD) ? ST_LOADWB : ST_FETCH;
        ST_LOADWB: state_q <= ST_FETCH;
        default:   state_q <= ST_FETCH;
      endcase
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = dmem_addr_q;
  assign dmem_we    = dmem_we_q;
  assign dmem_wdata = dmem_wdata_q;
  assign io_we      = io_we_q;
  assign io_addr    = io_addr_q;
  assign io_wdata   = io_wdata_q;
endmodule

// File: rtl/bc_chk.sv
module bc_chk
  import bc_pkg::*;
#(
  parameter int PC_W = 10
) (
  input logic            clk,
  input logic            rst,
  input state_e          state,
  input logic [PC_W-1:0] imem_addr,
  input logic            dmem_we,
  input logic            io_we
);
  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> (imem_addr == '0 && !dmem_we && !io_we));

  // R7
  store_pulse_chk: assert property (@(posedge clk) disable iff (rst) dmem_we |=> !dmem_we);

  // R9
  io_pulse_chk: assert property (@(posedge clk) disable iff (rst) io_we |=> !io_we);

  // R8
  second_word_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LATCH2) |=> (imem_addr == $past(imem_addr) + PC_W'(1)));

  // R7
  store_phase_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (state == ST_MEM));
endmodule

bind byte_core bc_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .state(state_q), .imem_addr(imem_addr),
  .dmem_we(dmem_we), .io_we(io_we)
);

// File: tb/byte_core_test.sv
`timescale 1ns/1ps
module byte_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  imem_addr;
  logic [15:0] imem_q;
  logic [15:0] dmem_addr;
  logic        dmem_we;
  logic [7:0]  dmem_wdata;
  logic [7:0]  dmem_rdata;
  logic        io_we;
  logic [5:0]  io_addr;
  logic [7:0]  io_wdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [15:0] prog [0:1023];
  int wp;

  logic [15:0] st_a [0:63];
  logic [7:0]  st_d [0:63];
  int          st_n;
  logic [5:0]  io_la [0:63];
  logic [7:0]  io_ld [0:63];
  int          io_n;

  always #10 clk = ~clk;

  byte_core uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_q),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata)
  );

  always @(posedge clk) begin
    imem_q     <= prog[imem_addr];
    dmem_rdata <= dmem_addr[7:0] ^ 8'hA5;
    if (rst) begin
      st_n <= 0;
      io_n <= 0;
    end else begin
      if (dmem_we && st_n < 64) begin
        st_a[st_n] <= dmem_addr; st_d[st_n] <= dmem_wdata; st_n <= st_n + 1;
      end
      if (io_we && io_n < 64) begin
        io_la[io_n] <= io_addr; io_ld[io_n] <= io_wdata; io_n <= io_n + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int find_st(input int addr);
    int v = -1;
    for (int i = 0; i < st_n; i++) if (int'(st_a[i]) == addr) v = int'(st_d[i]);
    return v;
  endfunction

  function automatic logic [15:0] w_r(input logic [3:0] op, input int d, input int r);
    return {op, 5'(d), 5'(r), 2'b00};
  endfunction
  function automatic logic [15:0] w_u(input int d, input int sel);
    return {4'h7, 5'(d), 5'd0, 2'(sel)};
  endfunction
  function automatic logic [15:0] w_ldi(input int d, input int k);
    return {4'h8, 4'(d - 16), 8'(k)};
  endfunction

  task automatic put(input logic [15:0] w);
    prog[wp] = w; wp++;
  endtask
  task automatic sts(input int r, input int addr);
    put({4'hA, 5'(r), 7'd0}); put(16'(addr));
  endtask
  task automatic lds(input int d, input int addr);
    put({4'h9, 5'(d), 7'd0}); put(16'(addr));
  endtask
  task automatic clear_prog();
    for (int i = 0; i < 1024; i++) prog[i] = 16'h0000;
    wp = 0;
  endtask

  task automatic run(input int cycles);
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    int tail;
    // sweep over operand pairs
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        int a = (i * 17) ^ ((i == 8) ? 8 : 0);
        int b = (j * 17) ^ ((j == 8) ? 8 : 0);
        clear_prog();
        put(w_ldi(16, a)); put(w_ldi(17, b));
        put(w_r(4'h1, 2, 16)); put(w_r(4'h2, 2, 17)); sts(2, 16'h10);
        put(w_r(4'h1, 3, 16)); put(w_r(4'h3, 3, 17)); sts(3, 16'h11);
        put(w_r(4'h1, 4, 16)); put(w_r(4'h4, 4, 17)); sts(4, 16'h12);
        put(w_r(4'h1, 5, 16)); put(w_r(4'h5, 5, 17)); sts(5, 16'h13);
        put(w_r(4'h6, 16, 17)); sts(0, 16'h14); sts(1, 16'h15);
        put(w_r(4'h1, 6, 16)); put(w_u(6, 0)); sts(6, 16'h16);
        put(w_r(4'h1, 7, 16)); put(w_u(7, 1)); sts(7, 16'h17);
        put(w_r(4'h1, 8, 16)); put(w_u(8, 2)); sts(8, 16'h18);
        sts(17, 16'h19); sts(16, 16'h1A);
        tail = wp;
        put({4'hD, 12'hFFF});
        run(160);
        chk("R2 or",         find_st(16'h10), a | b);
        chk("R2 and",        find_st(16'h11), a & b);
        chk("R2 add",        find_st(16'h12), (a + b) & 255);
        chk("R2 sub",        find_st(16'h13), (a - b) & 255);
        chk("R3 product lo", find_st(16'h14), (a * b) & 255);
        chk("R3 product hi", find_st(16'h15), (a * b) >> 8);
        chk("R4 inc",        find_st(16'h16), (a + 1) & 255);
        chk("R4 shift",      find_st(16'h17), (a << 1) & 255);
        chk("R4 negate",     find_st(16'h18), (256 - a) & 255);
        chk("R2 source kept",find_st(16'h19), b);
        chk("R3 operand kept", find_st(16'h1A), a);
        chk("R11 self jump pc", int'(imem_addr), tail);
      end
    end

    // directed program
    clear_prog();
    put(w_ldi(16, 0)); put(w_r(4'h1, 0, 16));
    put(w_ldi(16, 8'h11)); put(w_ldi(31, 8'h22));
    sts(0, 16'h50); sts(16, 16'h51); sts(31, 16'h52);
    put(16'hE000); put(16'hF7FF); put(16'h0123); put(w_u(16, 3));
    sts(16, 16'h53);
    lds(7, 16'h0040); sts(7, 16'h54);
    lds(8, 16'hFF00); sts(8, 16'hFFFF);
    put({4'hB, 5'd31, 1'b0, 6'd63});
    put(w_ldi(17, 8'h5A)); put({4'hB, 5'd17, 1'b0, 6'd31});
    put({4'hC, 5'd31, 4'd0, 3'd7});
    put({4'hC, 5'd31, 4'd0, 3'd1});
    put({4'hC, 5'd0, 4'd0, 3'd3});
    put({4'hD, 12'h001}); put(w_ldi(16, 8'hEE)); sts(16, 16'h55);
    tail = wp;
    put({4'hD, 12'hFFF});

    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state seen after reset edges
    chk("R1 pc after reset", int'(imem_addr), 0);
    chk("R1 no store in reset", int'(dmem_we), 0);
    chk("R1 no io in reset", int'(io_we), 0);
    rst = 1'b0;
    repeat (300) @(negedge clk);

    chk("R5 r0 untouched", find_st(16'h50), 0);
    chk("R5 r16 written", find_st(16'h51), 8'h11);
    chk("R5 r31 written", find_st(16'h52), 8'h22);
    chk("R12 illegal no effect", find_st(16'h53), 8'h11);
    chk("R6 load low addr", find_st(16'h54), 8'h40 ^ 8'hA5);
    chk("R7 store to top addr", find_st(16'hFFFF), 8'h00 ^ 8'hA5);
    chk("R11 skipped word", find_st(16'h55), 8'h11);
    chk("R12 store count", st_n, 7);
    chk("R9 io count", io_n, 5);
    chk("R9 out addr", int'(io_la[0]), 63);
    chk("R9 out data", int'(io_ld[0]), 8'h22);
    chk("R9 out data 2", int'(io_ld[1]), 8'h5A);
    chk("R10 set bit7 addr", int'(io_la[2]), 31);
    chk("R10 set bit7", int'(io_ld[2]), 8'hDA);
    chk("R10 set bit already set", int'(io_ld[3]), 8'hDA);
    chk("R10 addr0 bit3 addr", int'(io_la[4]), 0);
    chk("R10 addr0 bit3", int'(io_ld[4]), 8'h08);
    chk("R8 final pc", int'(imem_addr), tail);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule